// File: doc/BRIEF.md
# Integration Test Signal Multiplexer Bank

This block sits between a functional core and the rest of the chip and lets software take over the core's boundary signals. It has a small register bank on an APB-style slave port. One enable bit switches the block between two modes. In functional mode every boundary signal passes straight through. In integration mode each covered output and each intra-chip input is driven from a value held in a register. Software can then toggle every wire and show that the block is correctly connected, without running the core.

The block covers four kinds of signal. The serial data output pin and two banks of intra-chip outputs (29 and 13 wires) go from the core to the system. Two intra-chip DMA-clear inputs go from the system to the core. The serial data input pin can only be observed. Each kind reads back in its own way. The output pin reads back the value stored for it. Intra-chip signals read back the live value after their multiplexer, so in functional mode a read shows the functional value. The input pin reads back its current level.

The mode is held by a two-state machine. `MODE_FUNC` is entered at reset. The ENTER transition (a write to the control register with bit 0 set) moves it to `MODE_ITEST`. The LEAVE transition (a write with bit 0 clear) moves it back. Any other write to the control register keeps the current state.

Top module: `itest_mux_bank`

## Requirements
- R1: After reset, the control register at offset 0x180 reads 0, the machine is in `MODE_FUNC`, and all stored test values are zero. Offset 0x188 bit 29 reads 0.
- R2: In `MODE_FUNC`, `sys_sig_a`, `sys_sig_b` and `pin_sdata_out` equal their functional sources, and `core_dma_clr` equals `sys_dma_clr`. Writes to the test registers do not change these outputs.
- R3: A write to 0x180 with bit 0 = 1 enters `MODE_ITEST` at the clock edge of the access phase. 0x180 then reads 1, and every covered signal takes its stored test value.
- R4: Bits 1:0 of offset 0x184 are writable. In `MODE_ITEST` they drive `core_dma_clr[1:0]`. Reads of these bits return `core_dma_clr`, which is the output of the multiplexer in either mode.
- R5: Bit 2 of offset 0x184 is read-only and returns the live `pin_sdata_in` level. Writing bit 2 has no effect.
- R6: Bit 29 of offset 0x188 drives `pin_sdata_out` in `MODE_ITEST`. In both modes, reads of bit 29 return the value last written to it.
- R7: Bits 28:0 of offset 0x188 drive `sys_sig_a[28:0]`, and bits 12:0 of offset 0x18C drive `sys_sig_b[12:0]`, in `MODE_ITEST`. Reads of these bits return the multiplexer outputs.
- R8: Reserved bits read as zero and ignore writes. These are 0x180 bits 31:1, 0x184 bits 31:3, 0x188 bits 31:30 and 0x18C bits 31:13.
- R9: A read of any offset other than 0x180, 0x184, 0x188 or 0x18C returns zero. A write to such an offset changes no register and no output.
- R10: A write to 0x180 with bit 0 = 0 returns every multiplexer to its functional source from the same clock edge. The stored test values are kept, and they reappear on the next ENTER.
- R11: A register is written only on a clock edge where `psel`, `penable` and `pwrite` are all high. A setup phase on its own, or a read access, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write (1) or read (0) |
| paddr | input | ADDR_W (12) | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational, zero when not selected |
| func_sdata_out | input | 1 | Serial data output from the core |
| pin_sdata_out | output | 1 | Serial data output toward the pad |
| pin_sdata_in | input | 1 | Serial data input from the pad (observed only) |
| core_sig_a | input | NUM_A (29) | Intra-chip outputs bank A from the core |
| sys_sig_a | output | NUM_A (29) | Intra-chip outputs bank A toward the system |
| core_sig_b | input | NUM_B (13) | Intra-chip outputs bank B from the core |
| sys_sig_b | output | NUM_B (13) | Intra-chip outputs bank B toward the system |
| sys_dma_clr | input | NUM_CLR (2) | DMA-clear inputs from the system |
| core_dma_clr | output | NUM_CLR (2) | DMA-clear inputs delivered to the core |

## Verification
A register write, including an ENTER or LEAVE, takes effect on the rising edge that ends its access phase. The multiplexers are combinational after that edge, so the bench checks the boundary outputs on the falling edge that follows. Read data is combinational during the access phase, and the bench samples it one nanosecond after the falling edge that raises `penable`, before the next rising edge. Functional sources are changed only on falling edges, and their effect is checked at the same falling edge after a short delay, since they pass through no register.

// File: rtl/itest_mux_pkg.sv
package itest_mux_pkg;

    // Register offsets (byte addresses within the block window)
    localparam int unsigned OFF_CTRL = 32'h180;
    localparam int unsigned OFF_INP  = 32'h184;
    localparam int unsigned OFF_OUTA = 32'h188;
    localparam int unsigned OFF_OUTB = 32'h18C;

    // Mode state machine
    typedef enum logic {
        MODE_FUNC  = 1'b0,
        MODE_ITEST = 1'b1
    } itm_mode_e;

endpackage

// File: rtl/itest_mux_sel.sv
// Bank of 2:1 selectors: functional source or register-held test value.
module itest_mux_sel #(
    parameter int W = 1
) (
    input  logic         use_test,
    input  logic [W-1:0] fn_val,
    input  logic [W-1:0] tst_val,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = use_test ? tst_val[i] : fn_val[i];
    end

endmodule

// File: rtl/itest_mux_regs.sv
// Mode state machine and stored test values.
module itest_mux_regs
    import itest_mux_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_A   = 29,
    parameter int NUM_B   = 13,
    parameter int NUM_CLR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    output logic              test_en,
    output logic [31:0]       st_clr,
    output logic [31:0]       st_a,
    output logic [31:0]       st_b
);

    // Writable field masks; bank A carries the pin output bit at NUM_A
    localparam logic [31:0] MASK_CLR = (32'd1 << NUM_CLR) - 32'd1;
    localparam logic [31:0] MASK_A   = (32'd1 << (NUM_A + 1)) - 32'd1;
    localparam logic [31:0] MASK_B   = (32'd1 << NUM_B) - 32'd1;

    logic hit_ctrl, hit_inp, hit_outa, hit_outb;
    itm_mode_e state_q, state_d;

    assign hit_ctrl = wr_stb && (waddr == ADDR_W'(OFF_CTRL));
    assign hit_inp  = wr_stb && (waddr == ADDR_W'(OFF_INP));
    assign hit_outa = wr_stb && (waddr == ADDR_W'(OFF_OUTA));
    assign hit_outb = wr_stb && (waddr == ADDR_W'(OFF_OUTB));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_FUNC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: ENTER / LEAVE on control writes
    always_comb begin
        state_d = state_q;
        if (hit_ctrl) begin
            unique case (state_q)
                MODE_FUNC:  if (wdata[0])  state_d = MODE_ITEST;
                MODE_ITEST: if (!wdata[0]) state_d = MODE_FUNC;
            endcase
        end
    end

    // Outputs of the machine
    always_comb begin
        test_en = (state_q == MODE_ITEST);
    end

    // Stored test values, reserved bits masked off at write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_clr <= '0;
            st_a   <= '0;
            st_b   <= '0;
        end else begin
            if (hit_inp)  st_clr <= wdata & MASK_CLR;
            if (hit_outa) st_a   <= wdata & MASK_A;
            if (hit_outb) st_b   <= wdata & MASK_B;
        end
    end

endmodule

// File: rtl/itest_mux_rdata.sv
// Read-back selection; each signal class has its own source.
module itest_mux_rdata
    import itest_mux_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_A   = 29,
    parameter int NUM_B   = 13,
    parameter int NUM_CLR = 2
) (
    input  logic               sel,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               test_en,
    input  logic [31:0]        st_clr,
    input  logic [31:0]        st_a,
    input  logic [31:0]        st_b,
    input  logic               pin_in,
    input  logic [NUM_CLR-1:0] clr_live,
    input  logic [NUM_A-1:0]   a_live,
    input  logic [NUM_B-1:0]   b_live,
    output logic [31:0]        rdata
);

    localparam logic [31:0] LOW_CLR = (32'd1 << NUM_CLR) - 32'd1;
    localparam logic [31:0] LOW_A   = (32'd1 << NUM_A) - 32'd1;
    localparam logic [31:0] LOW_B   = (32'd1 << NUM_B) - 32'd1;

    logic [31:0] v_ctrl, v_inp, v_outa, v_outb;

    assign v_ctrl = {31'd0, test_en};
    assign v_inp  = (st_clr & ~LOW_CLR)
                  | (32'(pin_in) << NUM_CLR)
                  | {{(32-NUM_CLR){1'b0}}, clr_live};
    assign v_outa = (st_a & ~LOW_A) | {{(32-NUM_A){1'b0}}, a_live};
    assign v_outb = (st_b & ~LOW_B) | {{(32-NUM_B){1'b0}}, b_live};

    always_comb begin
        rdata = '0;
        if (sel) begin
            if (addr == ADDR_W'(OFF_CTRL))      rdata = v_ctrl;
            else if (addr == ADDR_W'(OFF_INP))  rdata = v_inp;
            else if (addr == ADDR_W'(OFF_OUTA)) rdata = v_outa;
            else if (addr == ADDR_W'(OFF_OUTB)) rdata = v_outb;
        end
    end

endmodule

// File: rtl/itest_mux_bank.sv
module itest_mux_bank #(
    parameter int ADDR_W  = 12,
    parameter int NUM_A   = 29,
    parameter int NUM_B   = 13,
    parameter int NUM_CLR = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic               func_sdata_out,
    output logic               pin_sdata_out,
    input  logic               pin_sdata_in,
    input  logic [NUM_A-1:0]   core_sig_a,
    output logic [NUM_A-1:0]   sys_sig_a,
    input  logic [NUM_B-1:0]   core_sig_b,
    output logic [NUM_B-1:0]   sys_sig_b,
    input  logic [NUM_CLR-1:0] sys_dma_clr,
    output logic [NUM_CLR-1:0] core_dma_clr
);

    logic        wr_stb;
    logic        test_en;
    logic [31:0] st_clr, st_a, st_b;

    assign wr_stb = psel && penable && pwrite;

    itest_mux_regs #(
        .ADDR_W(ADDR_W), .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_CLR(NUM_CLR)
    ) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .wr_stb  (wr_stb),
        .waddr   (paddr),
        .wdata   (pwdata),
        .test_en (test_en),
        .st_clr  (st_clr),
        .st_a    (st_a),
        .st_b    (st_b)
    );

    itest_mux_sel #(.W(NUM_A)) u_sel_a (
        .use_test (test_en),
        .fn_val   (core_sig_a),
        .tst_val  (st_a[NUM_A-1:0]),
        .y        (sys_sig_a)
    );

    itest_mux_sel #(.W(NUM_B)) u_sel_b (
        .use_test (test_en),
        .fn_val   (core_sig_b),
        .tst_val  (st_b[NUM_B-1:0]),
        .y        (sys_sig_b)
    );

    itest_mux_sel #(.W(NUM_CLR)) u_sel_clr (
        .use_test (test_en),
        .fn_val   (sys_dma_clr),
        .tst_val  (st_clr[NUM_CLR-1:0]),
        .y        (core_dma_clr)
    );

    itest_mux_sel #(.W(1)) u_sel_sdo (
        .use_test (test_en),
        .fn_val   (func_sdata_out),
        .tst_val  (st_a[NUM_A]),
        .y        (pin_sdata_out)
    );

    itest_mux_rdata #(
        .ADDR_W(ADDR_W), .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_CLR(NUM_CLR)
    ) u_rdata (
        .sel      (psel),
        .addr     (paddr),
        .test_en  (test_en),
        .st_clr   (st_clr),
        .st_a     (st_a),
        .st_b     (st_b),
        .pin_in   (pin_sdata_in),
        .clr_live (core_dma_clr),
        .a_live   (sys_sig_a),
        .b_live   (sys_sig_b),
        .rdata    (prdata)
    );

endmodule

// File: rtl/itest_mux_bank_chk.sv
module itest_mux_bank_chk #(
    parameter int ADDR_W  = 12,
    parameter int NUM_A   = 29,
    parameter int NUM_B   = 13,
    parameter int NUM_CLR = 2
) (
    input logic               pclk,
    input logic               presetn,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        prdata,
    input logic               func_sdata_out,
    input logic               pin_sdata_out,
    input logic               pin_sdata_in,
    input logic [NUM_A-1:0]   core_sig_a,
    input logic [NUM_A-1:0]   sys_sig_a,
    input logic [NUM_B-1:0]   core_sig_b,
    input logic [NUM_B-1:0]   sys_sig_b,
    input logic [NUM_CLR-1:0] sys_dma_clr,
    input logic [NUM_CLR-1:0] core_dma_clr,
    input logic               test_en
);

    logic known;
    assign known = (paddr == ADDR_W'(12'h180)) || (paddr == ADDR_W'(12'h184))
                || (paddr == ADDR_W'(12'h188)) || (paddr == ADDR_W'(12'h18C));

    assert_func_pass_R2: assert property (@(posedge pclk) disable iff (!presetn)
        !test_en |-> (sys_sig_a == core_sig_a) && (sys_sig_b == core_sig_b)
                  && (core_dma_clr == sys_dma_clr) && (pin_sdata_out == func_sdata_out));

    assert_enter_by_write_R3: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(test_en) |-> $past(psel && penable && pwrite && (paddr == ADDR_W'(12'h180))));

    assert_clr_readback_R4: assert property (@(posedge pclk) disable iff (!presetn)
        psel && (paddr == ADDR_W'(12'h184)) |-> (prdata[NUM_CLR-1:0] == core_dma_clr));

    assert_pin_in_R5: assert property (@(posedge pclk) disable iff (!presetn)
        psel && (paddr == ADDR_W'(12'h184)) |-> (prdata[NUM_CLR] == pin_sdata_in));

    assert_sdo_readback_R6: assert property (@(posedge pclk) disable iff (!presetn)
        test_en && psel && (paddr == ADDR_W'(12'h188)) |-> (prdata[NUM_A] == pin_sdata_out));

    assert_bank_readback_R7: assert property (@(posedge pclk) disable iff (!presetn)
        psel && (paddr == ADDR_W'(12'h18C)) |-> (prdata[NUM_B-1:0] == sys_sig_b));

    assert_reserved_zero_R8: assert property (@(posedge pclk) disable iff (!presetn)
        psel && (paddr == ADDR_W'(12'h180)) |-> (prdata[31:1] == 31'd0));

    assert_unmapped_zero_R9: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !known) || !psel |-> (prdata == 32'd0));

    assert_leave_restores_R10: assert property (@(posedge pclk) disable iff (!presetn)
        $fell(test_en) |-> (sys_sig_a == core_sig_a) && (pin_sdata_out == func_sdata_out));

    assert_write_qual_R11: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(test_en));

endmodule

bind itest_mux_bank itest_mux_bank_chk #(
    .ADDR_W(ADDR_W), .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_CLR(NUM_CLR)
) u_chk (
    .pclk           (pclk),
    .presetn        (presetn),
    .psel           (psel),
    .penable        (penable),
    .pwrite         (pwrite),
    .paddr          (paddr),
    .prdata         (prdata),
    .func_sdata_out (func_sdata_out),
    .pin_sdata_out  (pin_sdata_out),
    .pin_sdata_in   (pin_sdata_in),
    .core_sig_a     (core_sig_a),
    .sys_sig_a      (sys_sig_a),
    .core_sig_b     (core_sig_b),
    .sys_sig_b      (sys_sig_b),
    .sys_dma_clr    (sys_dma_clr),
    .core_dma_clr   (core_dma_clr),
    .test_en        (test_en)
);

// File: tb/itest_mux_bank_tb.sv
`timescale 1ns/100ps
module itest_mux_bank_tb;

    localparam int ADDR_W = 12;
    localparam int NUM_A = 29;
    localparam int NUM_B = 13;
    localparam int NUM_CLR = 2;

    logic               pclk = 1'b0;
    logic               presetn = 1'b0;
    logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]  paddr = '0;
    logic [31:0]        pwdata = '0;
    logic [31:0]        prdata;
    logic               func_sdata_out = 1'b0;
    logic               pin_sdata_out;
    logic               pin_sdata_in = 1'b0;
    logic [NUM_A-1:0]   core_sig_a = '0;
    logic [NUM_A-1:0]   sys_sig_a;
    logic [NUM_B-1:0]   core_sig_b = '0;
    logic [NUM_B-1:0]   sys_sig_b;
    logic [NUM_CLR-1:0] sys_dma_clr = '0;
    logic [NUM_CLR-1:0] core_dma_clr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 pclk = ~pclk;

    itest_mux_bank #(
        .ADDR_W(ADDR_W), .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_CLR(NUM_CLR)
    ) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .func_sdata_out(func_sdata_out), .pin_sdata_out(pin_sdata_out),
        .pin_sdata_in(pin_sdata_in), .core_sig_a(core_sig_a), .sys_sig_a(sys_sig_a),
        .core_sig_b(core_sig_b), .sys_sig_b(sys_sig_b),
        .sys_dma_clr(sys_dma_clr), .core_dma_clr(core_dma_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
        #1;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    // Output view packed the way offset 0x188 reads in test mode
    function automatic logic [31:0] ext_a(input logic [NUM_A-1:0] v);
        return {{(32-NUM_A){1'b0}}, v};
    endfunction

    initial begin
        repeat (100000) @(posedge pclk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] seed;
        repeat (4) @(negedge pclk);
        presetn = 1'b1;
        pin_sdata_in = 1'b1;
        core_sig_a = 29'h0AB1_2C3D;
        core_sig_b = 13'h1A5A;

        // R1 reset state
        bus_rd(12'h180, rd); chk("R1 ctrl reset", rd, 32'd0);
        bus_rd(12'h184, rd); chk("R1 inp reset", rd, 32'h4);
        bus_rd(12'h188, rd); chk("R1 outa reset", rd, ext_a(29'h0AB1_2C3D));

        // R2 functional pass-through over several patterns
        seed = 32'hC0FF_EE11;
        for (int k = 0; k < 8; k++) begin
            seed = lfsr(seed);
            core_sig_a = seed[NUM_A-1:0];
            core_sig_b = seed[31:31-NUM_B+1];
            sys_dma_clr = seed[1:0];
            func_sdata_out = seed[5];
            #1;
            chk("R2 bank a", ext_a(sys_sig_a), ext_a(seed[NUM_A-1:0]));
            chk("R2 bank b", {19'd0, sys_sig_b}, {19'd0, seed[31:19]});
            chk("R2 clr", {30'd0, core_dma_clr}, {30'd0, seed[1:0]});
            chk("R2 sdo", {31'd0, pin_sdata_out}, {31'd0, seed[5]});
            bus_rd(12'h184, rd);
            chk("R4 functional clr read", rd, {29'd0, 1'b1, seed[1:0]});
        end

        // R2/R6/R8 writes in functional mode leave pins alone
        core_sig_a = 29'h1555_5555; func_sdata_out = 1'b0;
        bus_wr(12'h188, 32'hFFFF_FFFF);
        chk("R2 bank a after write", ext_a(sys_sig_a), ext_a(29'h1555_5555));
        chk("R2 sdo after write", {31'd0, pin_sdata_out}, 32'd0);
        bus_rd(12'h188, rd);
        chk("R6 R8 outa read func", rd, 32'h2000_0000 | ext_a(29'h1555_5555));

        // R3 enter
        bus_wr(12'h180, 32'h1);
        chk("R3 bank a test", ext_a(sys_sig_a), 32'h1FFF_FFFF);
        chk("R3 sdo test", {31'd0, pin_sdata_out}, 32'd1);
        chk("R3 bank b test", {19'd0, sys_sig_b}, 32'd0);
        bus_rd(12'h180, rd); chk("R3 ctrl read", rd, 32'd1);

        // R6 R7 walking one across bank A and the pin bit
        for (int i = 0; i <= NUM_A; i++) begin
            bus_wr(12'h188, 32'd1 << i);
            chk("R7 walk a", ext_a(sys_sig_a), (i < NUM_A) ? (32'd1 << i) : 32'd0);
            chk("R6 walk sdo", {31'd0, pin_sdata_out}, (i == NUM_A) ? 32'd1 : 32'd0);
            bus_rd(12'h188, rd);
            chk("R7 walk a read", rd, 32'd1 << i);
        end

        // R7 walking one across bank B
        for (int i = 0; i < NUM_B; i++) begin
            bus_wr(12'h18C, 32'd1 << i);
            chk("R7 walk b", {19'd0, sys_sig_b}, 32'd1 << i);
            bus_rd(12'h18C, rd);
            chk("R7 walk b read", rd, 32'd1 << i);
        end
        bus_wr(12'h18C, 32'hFFFF_FFFF);
        bus_rd(12'h18C, rd); chk("R8 outb reserved", rd, 32'h0000_1FFF);
        bus_wr(12'h188, 32'hFFFF_FFFF);
        bus_rd(12'h188, rd); chk("R8 outa reserved", rd, 32'h3FFF_FFFF);

        // R4 R5 all clear codes, with bit 2 written and pin toggled
        for (int v = 0; v < 4; v++) begin
            pin_sdata_in = v[0];
            sys_dma_clr = ~v[1:0];
            bus_wr(12'h184, 32'hFFFF_FFFC | 32'(v));
            chk("R4 clr drive", {30'd0, core_dma_clr}, 32'(v));
            bus_rd(12'h184, rd);
            chk("R5 R8 inp read", rd, {29'd0, v[0], v[1:0]});
        end

        // R9 unmapped offsets
        bus_wr(12'h18C, 32'h0000_0A0A);
        bus_wr(12'h190, 32'hFFFF_FFFF);
        bus_wr(12'h17C, 32'hFFFF_FFFF);
        bus_wr(12'h000, 32'hFFFF_FFFF);
        chk("R9 bank b untouched", {19'd0, sys_sig_b}, 32'h0A0A);
        bus_rd(12'h190, rd); chk("R9 read 0x190", rd, 32'd0);
        bus_rd(12'h17C, rd); chk("R9 read 0x17C", rd, 32'd0);
        bus_rd(12'h18C, rd); chk("R9 bank b read", rd, 32'h0A0A);

        // R11 setup-only phase and read access with data present
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h18C; pwdata = 32'h0000_1111;
        @(negedge pclk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h18C; pwdata = 32'h0000_0777;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwdata = '0;
        #1;
        chk("R11 bank b unchanged", {19'd0, sys_sig_b}, 32'h0A0A);

        // R10 leave restores functional, values kept
        bus_wr(12'h188, 32'h2AAA_AAAA);
        bus_wr(12'h184, 32'h1);
        core_sig_a = 29'h0123_4567; func_sdata_out = 1'b0; sys_dma_clr = 2'b10;
        bus_wr(12'h180, 32'hFFFF_FFFE);
        chk("R10 bank a func", ext_a(sys_sig_a), ext_a(29'h0123_4567));
        chk("R10 sdo func", {31'd0, pin_sdata_out}, 32'd0);
        chk("R10 clr func", {30'd0, core_dma_clr}, 32'd2);
        chk("R10 bank b func", {19'd0, sys_sig_b}, {19'd0, core_sig_b});
        bus_rd(12'h180, rd); chk("R10 R8 ctrl read", rd, 32'd0);
        bus_wr(12'h180, 32'h1);
        chk("R10 bank a kept", ext_a(sys_sig_a), 32'h0AAA_AAAA);
        chk("R10 sdo kept", {31'd0, pin_sdata_out}, 32'd1);
        chk("R10 clr kept", {30'd0, core_dma_clr}, 32'd1);
        chk("R10 bank b kept", {19'd0, sys_sig_b}, 32'h0A0A);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule